// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the memory address sequence for one DMA channel that moves words between a peripheral and memory. Software loads a start address, a row length (inner count) and its signed stride, a row count (outer count) and its signed stride, a word size, and a control word. The peripheral then asks for words. Each cycle in which its request meets the channel's grant, the block presents one address with a strobe. Within a row the address advances by the inner stride. At the last word of a row it advances by the outer stride instead, so rows can sit back to back or leave a gap between them.

The channel has two modes. In repeat mode, after the last word of the last row, the working address and both counters reload their programmed values in the same cycle, and the channel keeps running with no idle cycle. This forms a circular buffer, or a double buffer when the outer count is 2. In one-shot mode the whole transfer runs once and then the channel goes idle. An end-of-row interrupt flag and an end-of-transfer interrupt flag can each be enabled on its own. Software clears these flags by writing 1 to them. A read port shows the live address, the remaining counts and the running state.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset the channel is idle: `xfer_gnt` and `mem_strobe` are 0, both interrupt lines are 0, and the status word (read select 3) is 0.
- R2: `mem_strobe` is high exactly in cycles where `xfer_req` is high and the channel is running. In such a cycle `mem_addr` is the address of the current word, and exactly one word is consumed.
- R3: Within a row, each word's address is the previous word's address plus the inner stride (write select 1), read as signed two's complement. The address wraps modulo 2^ADDR_W.
- R4: After the last word of a row that is not the final row, the next address is the last address plus the outer stride (write select 4, signed). The inner count restarts and the remaining row count drops by one.
- R5: In one-shot mode (control bit 1 = 0), after inner count × outer count words the channel goes idle and `xfer_gnt` falls.
- R6: In repeat mode (control bit 1 = 1), the word after the final word of the transfer uses the start address (write select 0), with no idle cycle in between, and the sequence repeats.
- R7: A programmed inner or outer count (write selects 2 and 3) of 0 means 2^CNT_W.
- R8: When control bit 2 is set, the row flag (status bit 1, output `irq_row`) is set after any row ends. When the bit is clear, row ends leave the flag at 0.
- R9: When control bit 3 is set, the done flag (status bit 2, output `irq_done`) is set after the final word of the transfer. When the bit is clear, the flag stays 0.
- R10: Writing to select 6 clears each flag whose data bit is 1 (bit 0 = row flag, bit 1 = done flag).
- R11: A write to control (select 5) with bit 0 = 1 while idle starts the channel. While running, writes to selects 0 to 4 are ignored, and a control write with bit 0 = 0 halts the channel.
- R12: Read select 0 returns the current address. Select 1 returns the remaining inner count (the words left in the row, including the current word). Select 2 returns the remaining outer count (the rows left, including the current row). Select 3 returns {done flag, row flag, running} in bits 2..0.
- R13: `mem_size` equals control bits 5:4 as last written while idle (0 = 8-bit, 1 = 16-bit, 2 = 32-bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register write select |
| cfg_wdata | input | DATA_W | Register write data |
| rd_sel | input | 2 | Status read select |
| rd_data | output | DATA_W | Status read data |
| xfer_req | input | 1 | Peripheral word request |
| xfer_gnt | output | 1 | Channel grant (running) |
| mem_addr | output | ADDR_W | Address of the current word |
| mem_strobe | output | 1 | One word moves this cycle |
| mem_size | output | 2 | Programmed word size code |
| irq_row | output | 1 | End-of-row interrupt flag |
| irq_done | output | 1 | End-of-transfer interrupt flag |

## Verification
The assertions assume that software starts the channel only by writing the control register, and never starts it again while it is already running. They also assume that a start and a halt cannot occur in the same cycle. The stimulus keeps within these limits: it writes configuration only while the channel is idle, except in the one case that checks that writes made while running are ignored, and it halts the channel only while it is running. The peripheral request follows a pattern with gaps, so both idle cycles and back-to-back words appear across rows and at the wrap.

// File: rtl/dma2d_pkg.sv
// Package dma2d_pkg: register select codes and control bit positions
// shared by the register bank, the top level and the bench.
package dma2d_pkg;
    localparam logic [2:0] SEL_START = 3'd0;
    localparam logic [2:0] SEL_XSTR  = 3'd1;
    localparam logic [2:0] SEL_XCNT  = 3'd2;
    localparam logic [2:0] SEL_YCNT  = 3'd3;
    localparam logic [2:0] SEL_YSTR  = 3'd4;
    localparam logic [2:0] SEL_CTRL  = 3'd5;
    localparam logic [2:0] SEL_IRQ   = 3'd6;

    localparam int CB_EN   = 0;
    localparam int CB_AUTO = 1;
    localparam int CB_RIE  = 2;
    localparam int CB_DIE  = 3;
    localparam int CB_SZ   = 4;

    localparam logic [1:0] RD_ADDR = 2'd0;
    localparam logic [1:0] RD_XREM = 2'd1;
    localparam logic [1:0] RD_YREM = 2'd2;
    localparam logic [1:0] RD_STAT = 2'd3;
endpackage

// File: rtl/dma2d_regs.sv
// dma2d_regs: configuration register bank.
// Holds the setup values, decodes start/halt from control writes and
// produces write-1-to-clear pulses. Assumes ADDR_W <= DATA_W and that the
// control fields fit in DATA_W. Setup values are frozen while running.
module dma2d_regs
    import dma2d_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 16,
    parameter int STRIDE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [2:0]                 cfg_sel,
    input  logic [DATA_W-1:0]          cfg_wdata,
    input  logic                       running,
    output logic [ADDR_W-1:0]          start_addr,
    output logic [CNT_W-1:0]           xcnt,
    output logic [CNT_W-1:0]           ycnt,
    output logic signed [STRIDE_W-1:0] xstride,
    output logic signed [STRIDE_W-1:0] ystride,
    output logic                       auto_mode,
    output logic                       row_ie,
    output logic                       done_ie,
    output logic [1:0]                 wsize,
    output logic                       start,
    output logic                       stop,
    output logic [1:0]                 w1c
);
    logic ctrl_wr;

    // Decode a control-register write.
    always_comb ctrl_wr = cfg_we && (cfg_sel == SEL_CTRL);

    // Start/halt pulses and write-1-to-clear decode.
    always_comb begin
        start = ctrl_wr && cfg_wdata[CB_EN] && !running;
        stop  = ctrl_wr && !cfg_wdata[CB_EN] && running;
        w1c   = (cfg_we && cfg_sel == SEL_IRQ) ? cfg_wdata[1:0] : 2'b00;
    end

    // Setup registers: accept writes only while the channel is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_addr <= '0;
            xcnt       <= '0;
            ycnt       <= '0;
            xstride    <= '0;
            ystride    <= '0;
            auto_mode  <= 1'b0;
            row_ie     <= 1'b0;
            done_ie    <= 1'b0;
            wsize      <= 2'd0;
        end else if (cfg_we && !running) begin
            case (cfg_sel)
                SEL_START: start_addr <= cfg_wdata[ADDR_W-1:0];
                SEL_XSTR:  xstride    <= cfg_wdata[STRIDE_W-1:0];
                SEL_XCNT:  xcnt       <= cfg_wdata[CNT_W-1:0];
                SEL_YCNT:  ycnt       <= cfg_wdata[CNT_W-1:0];
                SEL_YSTR:  ystride    <= cfg_wdata[STRIDE_W-1:0];
                SEL_CTRL: begin
                    auto_mode <= cfg_wdata[CB_AUTO];
                    row_ie    <= cfg_wdata[CB_RIE];
                    done_ie   <= cfg_wdata[CB_DIE];
                    wsize     <= cfg_wdata[CB_SZ+1:CB_SZ];
                end
                default: ;
            endcase
        end
    end

    // R11: setup values hold while the channel runs.
    a_r11_frozen_setup: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cfg_we) |=> ($stable(start_addr) && $stable(xcnt) && $stable(ycnt)
                                 && $stable(xstride) && $stable(ystride)));
endmodule

// File: rtl/dma2d_counters.sv
// dma2d_counters: inner/outer loop counters and the run state.
// A loaded count of 0 walks through all 2^CNT_W values. Assumes start is
// only raised while idle and never together with stop.
module dma2d_counters #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             beat,
    input  logic             auto_mode,
    input  logic [CNT_W-1:0] xcnt,
    input  logic [CNT_W-1:0] ycnt,
    output logic             running,
    output logic [CNT_W-1:0] x_rem,
    output logic [CNT_W-1:0] y_rem,
    output logic             row_end,
    output logic             blk_end
);
    logic x_last, y_last;

    // Last-word detection for the current row and the current block.
    always_comb begin
        x_last  = (x_rem == CNT_W'(1));
        y_last  = (y_rem == CNT_W'(1));
        row_end = beat && x_last;
        blk_end = row_end && y_last;
    end

    // Counter and run-state update per word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            x_rem   <= '0;
            y_rem   <= '0;
        end else if (start) begin
            running <= 1'b1;
            x_rem   <= xcnt;
            y_rem   <= ycnt;
        end else if (stop) begin
            running <= 1'b0;
        end else if (beat) begin
            if (x_last) begin
                x_rem <= xcnt;
                if (y_last) begin
                    y_rem <= ycnt;
                    if (!auto_mode) running <= 1'b0;
                end else begin
                    y_rem <= y_rem - CNT_W'(1);
                end
            end else begin
                x_rem <= x_rem - CNT_W'(1);
            end
        end
    end

    // R5: one-shot mode drops to idle after the final word.
    a_r5_oneshot_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_end && !auto_mode) |=> !running);
    // R6: repeat mode reloads both counts and keeps running.
    a_r6_auto_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_end && auto_mode && !stop) |=> (running && x_rem == $past(xcnt) && y_rem == $past(ycnt)));
    // R4: a row end restarts the inner count and consumes one row.
    a_r4_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        (row_end && !blk_end && !stop) |=> (x_rem == $past(xcnt) && y_rem == $past(y_rem) - CNT_W'(1)));
endmodule

// File: rtl/dma2d_addr.sv
// dma2d_addr: working address accumulator.
// Adds the sign-extended inner stride per word, or the outer stride on the
// last word of a row; reloads the start address on load. Assumes
// STRIDE_W <= ADDR_W.
module dma2d_addr #(
    parameter int ADDR_W   = 32,
    parameter int STRIDE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic                       beat,
    input  logic                       row_end,
    input  logic [ADDR_W-1:0]          start_addr,
    input  logic signed [STRIDE_W-1:0] xstride,
    input  logic signed [STRIDE_W-1:0] ystride,
    output logic [ADDR_W-1:0]          cur_addr
);
    logic [ADDR_W-1:0] xs_ext, ys_ext, step;

    // Sign-extend the strides and choose the one for this word.
    always_comb begin
        xs_ext = ADDR_W'(xstride);
        ys_ext = ADDR_W'(ystride);
        step   = row_end ? ys_ext : xs_ext;
    end

    // Address register: reload or advance.
    always_ff @(posedge clk) begin
        if (!rst_n)     cur_addr <= '0;
        else if (load)  cur_addr <= start_addr;
        else if (beat)  cur_addr <= cur_addr + step;
    end

    // R3: within a row the address moves by the inner stride.
    a_r3_inner_step: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !row_end && !load) |=> (cur_addr == $past(cur_addr) + $past(xs_ext)));
    // R6: a reload presents the start address next cycle.
    a_r6_reload_addr: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cur_addr == $past(start_addr)));
endmodule

// File: rtl/dma2d_irq.sv
// dma2d_irq: row and done interrupt flags.
// Flags are set by enabled events and cleared by write-1; a set in the
// same cycle as a clear wins.
module dma2d_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_row,
    input  logic       set_done,
    input  logic [1:0] w1c,
    output logic       flag_row,
    output logic       flag_done
);
    // Flag registers with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_row  <= 1'b0;
            flag_done <= 1'b0;
        end else begin
            if (set_row)      flag_row  <= 1'b1;
            else if (w1c[0])  flag_row  <= 1'b0;
            if (set_done)     flag_done <= 1'b1;
            else if (w1c[1])  flag_done <= 1'b0;
        end
    end

    // R9: an enabled block end raises the done flag.
    a_r9_done_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_done |=> flag_done);
    // R10: write-1 clears the row flag when no new event arrives.
    a_r10_row_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c[0] && !set_row) |=> !flag_row);
endmodule

// File: rtl/dma2d_addr_gen.sv
// dma2d_addr_gen: two-dimensional DMA address generator, top level.
// Connects the register bank, loop counters, address accumulator and
// interrupt flags, and drives the handshake, address and status read port.
// Assumes the peripheral holds xfer_req only while it can take a word.
module dma2d_addr_gen
    import dma2d_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 16,
    parameter int STRIDE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              xfer_req,
    output logic              xfer_gnt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_strobe,
    output logic [1:0]        mem_size,
    output logic              irq_row,
    output logic              irq_done
);
    logic [ADDR_W-1:0]          start_addr, cur_addr;
    logic [CNT_W-1:0]           xcnt, ycnt, x_rem, y_rem;
    logic signed [STRIDE_W-1:0] xstride, ystride;
    logic auto_mode, row_ie, done_ie, start, stop, running, beat;
    logic row_end, blk_end, load, flag_row, flag_done;
    logic [1:0] wsize, w1c;

    dma2d_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .STRIDE_W(STRIDE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .running(running), .start_addr(start_addr), .xcnt(xcnt), .ycnt(ycnt),
        .xstride(xstride), .ystride(ystride), .auto_mode(auto_mode), .row_ie(row_ie),
        .done_ie(done_ie), .wsize(wsize), .start(start), .stop(stop), .w1c(w1c));

    dma2d_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .beat(beat),
        .auto_mode(auto_mode), .xcnt(xcnt), .ycnt(ycnt), .running(running),
        .x_rem(x_rem), .y_rem(y_rem), .row_end(row_end), .blk_end(blk_end));

    dma2d_addr #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(load), .beat(beat), .row_end(row_end),
        .start_addr(start_addr), .xstride(xstride), .ystride(ystride), .cur_addr(cur_addr));

    dma2d_irq u_irq (
        .clk(clk), .rst_n(rst_n), .set_row(row_end && row_ie), .set_done(blk_end && done_ie),
        .w1c(w1c), .flag_row(flag_row), .flag_done(flag_done));

    // Handshake, word strobe and address reload selection.
    always_comb begin
        beat       = xfer_req && running;
        load       = start || (blk_end && auto_mode);
        xfer_gnt   = running;
        mem_strobe = beat;
        mem_addr   = cur_addr;
        mem_size   = wsize;
        irq_row    = flag_row;
        irq_done   = flag_done;
    end

    // Status read multiplexer.
    always_comb begin
        case (rd_sel)
            RD_ADDR: rd_data = DATA_W'(cur_addr);
            RD_XREM: rd_data = DATA_W'(x_rem);
            RD_YREM: rd_data = DATA_W'(y_rem);
            default: rd_data = DATA_W'({flag_done, flag_row, running});
        endcase
    end
endmodule

// File: tb/dma2d_addr_gen_bench.sv
module dma2d_addr_gen_bench;
    import dma2d_pkg::*;
    localparam int DW = 32, AW = 16, CW = 3, SW = 8;
    localparam int CMAX = 1 << CW;

    logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, xfer_req = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [1:0] rd_sel = '0;
    logic [DW-1:0] rd_data;
    logic xfer_gnt, mem_strobe, irq_row, irq_done;
    logic [AW-1:0] mem_addr;
    logic [1:0] mem_size;
    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dma2d_addr_gen #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW), .STRIDE_W(SW)) u_dma2d_addr_gen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .rd_sel(rd_sel), .rd_data(rd_data), .xfer_req(xfer_req), .xfer_gnt(xfer_gnt),
        .mem_addr(mem_addr), .mem_strobe(mem_strobe), .mem_size(mem_size),
        .irq_row(irq_row), .irq_done(irq_done));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] sel, input int exp, input string tag);
        rd_sel = sel;
        #1;
        chk(rd_data == DW'(exp), tag, int'(rd_data), exp);
    endtask

    function automatic int eaddr(int st, int x, int y, int xs, int ys, int k);
        int kk = k % (x * y);
        return (st + (kk / x) * ((x - 1) * xs + ys) + (kk % x) * xs) & ((1 << AW) - 1);
    endfunction

    // Drive req with gaps and compare each word; returns after n words.
    task automatic run_words(input int st, input int x, input int y, input int xs,
                             input int ys, input int k0, input int n);
        int k = k0;
        int cyc = 0;
        while (k < k0 + n) begin
            @(negedge clk);
            xfer_req = (cyc % 3) != 2;
            #1;
            chk(mem_strobe == xfer_req, "R2 strobe", int'(mem_strobe), int'(xfer_req));
            if (xfer_req) begin
                chk(int'(mem_addr) == eaddr(st, x, y, xs, ys, k), "R3/R4/R6 address",
                    int'(mem_addr), eaddr(st, x, y, xs, ys, k));
                k++;
            end
            cyc++;
        end
        @(negedge clk);
        xfer_req = 1'b0;
    endtask

    task automatic run_case(input int xc, input int yc, input int xs, input int ys,
                            input bit aut, input bit rie, input bit die, input int st);
        int x = (xc == 0) ? CMAX : xc;
        int y = (yc == 0) ? CMAX : yc;
        int sz = (xc + yc) % 3;
        wr(SEL_START, st);
        wr(SEL_XCNT, xc);
        wr(SEL_XSTR, xs & 8'hFF);
        wr(SEL_YCNT, yc);
        wr(SEL_YSTR, ys & 8'hFF);
        wr(SEL_CTRL, (sz << CB_SZ) | (int'(die) << CB_DIE) | (int'(rie) << CB_RIE)
                     | (int'(aut) << CB_AUTO) | 1);
        #1;
        chk(mem_size == 2'(sz), "R13 size", int'(mem_size), sz);
        chk(xfer_gnt == 1'b1, "R11 start", int'(xfer_gnt), 1);
        run_words(st, x, y, xs, ys, 0, aut ? x * y + x + 1 : x * y);
        #1;
        if (!aut) begin
            chk(xfer_gnt == 1'b0, "R5 idle after block", int'(xfer_gnt), 0);
        end else begin
            chk(xfer_gnt == 1'b1, "R6 still running", int'(xfer_gnt), 1);
            wr(SEL_CTRL, 0);
            #1;
            chk(xfer_gnt == 1'b0, "R11 halt", int'(xfer_gnt), 0);
        end
        chk(irq_row == rie, "R8 row line", int'(irq_row), int'(rie));
        chk(irq_done == die, "R9 done line", int'(irq_done), int'(die));
        rd_chk(RD_STAT, (int'(die) << 2) | (int'(rie) << 1), "R12 status after run");
        wr(SEL_IRQ, 3);
        rd_chk(RD_STAT, 0, "R10 flags cleared");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int xcs[4] = '{1, 2, 3, 0};
        int xss[3] = '{1, 4, -2};
        int yss[3] = '{1, 12, -3};
        xfer_req = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state, even with a request pending.
        chk(xfer_gnt == 1'b0, "R1 gnt", int'(xfer_gnt), 0);
        chk(mem_strobe == 1'b0, "R1 strobe", int'(mem_strobe), 0);
        chk(irq_row == 1'b0 && irq_done == 1'b0, "R1 irq", int'({irq_row, irq_done}), 0);
        rd_chk(RD_STAT, 0, "R1 status");
        xfer_req = 1'b0;
        rst_n = 1'b1;

        // Sweep: counts (incl. 0 = max, R7), signed strides, both modes.
        for (int a = 0; a < 4; a++)
            for (int b = 1; b <= 3; b++)
                for (int s = 0; s < 3; s++)
                    for (int m = 0; m < 2; m++)
                        run_case(xcs[a], b, xss[s], yss[s], m[0], b != 2, s != 1,
                                 16'hFFF0 + a * 64 + s);
        // R7: outer count 0 means 2^CNT_W rows.
        run_case(2, 0, 2, 3, 1'b0, 1'b1, 1'b1, 16'h0400);

        // R11/R12: status mid-run, writes while running are ignored.
        wr(SEL_START, 16'h0100); wr(SEL_XCNT, 3); wr(SEL_XSTR, 2);
        wr(SEL_YCNT, 2); wr(SEL_YSTR, 5); wr(SEL_CTRL, 1);
        run_words(16'h0100, 3, 2, 2, 5, 0, 4);
        rd_chk(RD_ADDR, eaddr(16'h0100, 3, 2, 2, 5, 4), "R12 address");
        rd_chk(RD_XREM, 2, "R12 inner remaining");
        rd_chk(RD_YREM, 1, "R12 outer remaining");
        rd_chk(RD_STAT, 1, "R12 running bit");
        wr(SEL_START, 16'h7777);
        wr(SEL_XCNT, 1);
        wr(SEL_YSTR, 99);
        run_words(16'h0100, 3, 2, 2, 5, 4, 2);
        #1;
        chk(xfer_gnt == 1'b0, "R11 ignored writes, R5 idle", int'(xfer_gnt), 0);
        chk(irq_row == 1'b0 && irq_done == 1'b0, "R8/R9 disabled flags stay clear",
            int'({irq_row, irq_done}), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule